// File: doc/BRIEF.md
# Queue Pointer Controller

This block keeps the read pointer, write pointer, configured size and two sticky status flags for each of a parameterised set of hardware queues. Producers and consumers never load a pointer directly. They move it forward by posting bounded "add" writes on a simple register bus. Either side can read both pointers back through two status registers per queue. A config register sets the queue's size as a power of two and restarts the queue.

Each queue owns a 0x800-byte window. The windows start at offset 0x80000 of the bus address space. Bits 18:11 of the address select the queue. The block drives one not-empty line per queue, so that downstream logic can see pending work without polling.

Top module: `qptr_ctrl`

## Requirements
- R1: A queue's window begins at address 0x80000 + n*0x800, and address bits 18:11 give the queue index n. Within the window there are five registers: 0x0 adds to the read pointer, 0x4 adds to the write pointer, 0x8 is status-low, 0xC is status-high and 0x10 is config. The two add offsets read as zero.
- R2: A write of a value from 0 to 63 to offset 0x4 advances the write pointer by that value, modulo 2^L, where L is the configured log2 size. The change is visible from the cycle after the strobe.
- R3: A write of a value from 0 to 63 to offset 0x0 advances the read pointer by that value, modulo 2^L.
- R4: An add whose 32-bit value exceeds 63 changes neither pointer. It sets a sticky error flag, which is reported in bit 31 of status-high.
- R5: An accepted write-pointer add sets a sticky overflow flag, reported in bit 30 of status-high, when ((wr - rd) mod 2^L) + value > 2^L - 1. The write pointer still advances.
- R6: Status-low returns the read pointer in bits 17:0 and an empty bit in bit 31. Empty is 1 when the read pointer equals the write pointer. Status-high returns the write pointer in bits 17:0.
- R7: A write to config takes L from bits 4:0, clamped to the range 8 to 18. The same write clears both pointers, the overflow flag and the error flag. Config reads back L in bits 4:0.
- R8: q_not_empty[n] is 1 exactly when queue n's read and write pointers differ.
- R9: bus_rdata carries the addressed register's value in the cycle after a read strobe. It is zero in any cycle that does not follow a read strobe.
- R10: The following addresses read as zero, and writes to them change no queue state: addresses outside the queue region, addresses whose queue index is NUM_Q or above, and window offsets other than the five listed.
- R11: After reset, every pointer is zero, both flags are clear and L is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| q_not_empty | output | NUM_Q | Per-queue pointers-differ indication |

## Verification
The bench builds the block with NUM_Q = 4 and ADDR_W = 20. This puts the first unmapped queue index, 4, within reach of the unmapped-address checks.

The bench sweeps every legal add value, 0 through 63, on both pointers of every queue at the minimum size of 256 entries. With that size, the running totals wrap the pointers several times and cross the overflow threshold repeatedly. Separate cases cover:
- the exact full/overflow boundary;
- the largest size;
- clamping of the configured size.

// File: rtl/qptr_pkg.sv
// Package: shared constants and types for the queue pointer controller.
// Assumes 32-bit bus data and 18-bit pointer fields.
package qptr_pkg;
    localparam int DATA_W  = 32;
    localparam int PTR_W   = 18;
    localparam int LG_W    = 5;
    localparam int MAX_ADD = 63;
    localparam int LG_MIN  = 8;
    localparam int LG_MAX  = 18;
    localparam int WIN_W   = 11;   // 0x800-byte window per queue
    localparam int QIDX_W  = 8;    // queue index field width

    // Register selected inside a queue window
    typedef enum logic [2:0] {
        RK_NONE   = 3'd0,
        RK_ADD_RD = 3'd1,
        RK_ADD_WR = 3'd2,
        RK_STS_LO = 3'd3,
        RK_STS_HI = 3'd4,
        RK_CFG    = 3'd5
    } reg_kind_e;

    // Per-queue state as seen by the read path
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [LG_W-1:0]  lg;
        logic             ovf;
        logic             err;
    } qstat_t;
endpackage

// File: rtl/qptr_decode.sv
// Module: qptr_decode
// Maps a bus byte address to a queue index and register kind.
// Assumes a single region marker value of 1 above the queue index bits
// (0x80000 for a 20-bit address); unmapped addresses yield RK_NONE.
module qptr_decode
    import qptr_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [QIDX_W-1:0] qidx,
    output reg_kind_e         kind
);
    localparam int REGION_W = ADDR_W - WIN_W - QIDX_W;

    logic [REGION_W-1:0] region;
    logic [WIN_W-1:0]    offs;

    assign region = addr[ADDR_W-1 -: REGION_W];
    assign qidx   = addr[WIN_W +: QIDX_W];
    assign offs   = addr[WIN_W-1:0];

    // Purpose: classify the window offset when region and index are valid
    always_comb begin
        kind = RK_NONE;
        if (region == REGION_W'(1) && 32'(qidx) < NUM_Q) begin
            case (offs)
                11'h000: kind = RK_ADD_RD;
                11'h004: kind = RK_ADD_WR;
                11'h008: kind = RK_STS_LO;
                11'h00C: kind = RK_STS_HI;
                11'h010: kind = RK_CFG;
                default: kind = RK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/qptr_queue.sv
// Module: qptr_queue
// Holds one queue's pointers, log2 size and sticky flags. Pointers move
// only by bounded adds and wrap at the configured power-of-two size.
// Assumes at most one of the three enables is high in any cycle.
module qptr_queue
    import qptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_rd_en,
    input  logic              add_wr_en,
    input  logic              cfg_en,
    input  logic [DATA_W-1:0] wdata,
    output qstat_t            stat,
    output logic              not_empty
);
    logic [PTR_W-1:0] rd_q, wr_q, mask, occ;
    logic [LG_W-1:0]  lg_q, lg_req;
    logic             ovf_q, err_q, add_ok, ovf_hit;
    logic [PTR_W:0]   occ_next;
    logic [PTR_W-1:0] add_val;

    assign mask     = PTR_W'((32'd1 << lg_q) - 32'd1);
    assign add_ok   = (wdata <= DATA_W'(MAX_ADD));
    assign add_val  = PTR_W'(wdata[5:0]);
    assign occ      = (wr_q - rd_q) & mask;
    assign occ_next = {1'b0, occ} + {1'b0, add_val};
    assign ovf_hit  = occ_next > {1'b0, mask};

    // Purpose: clamp the requested log2 size into the legal range
    always_comb begin
        lg_req = wdata[LG_W-1:0];
        if (lg_req < LG_W'(LG_MIN)) lg_req = LG_W'(LG_MIN);
        else if (lg_req > LG_W'(LG_MAX)) lg_req = LG_W'(LG_MAX);
    end

    // Purpose: update pointers, size and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            lg_q  <= LG_W'(LG_MIN);
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else if (cfg_en) begin
            lg_q  <= lg_req;
            rd_q  <= '0;
            wr_q  <= '0;
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (add_wr_en) begin
                if (add_ok) begin
                    wr_q <= (wr_q + add_val) & mask;
                    if (ovf_hit) ovf_q <= 1'b1;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (add_rd_en) begin
                if (add_ok) rd_q  <= (rd_q + add_val) & mask;
                else        err_q <= 1'b1;
            end
        end
    end

    assign stat      = '{rd: rd_q, wr: wr_q, lg: lg_q, ovf: ovf_q, err: err_q};
    assign not_empty = (rd_q != wr_q);

    // R2
    wr_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_wr_en && add_ok) |=>
            wr_q == (($past(wr_q) + PTR_W'($past(wdata))) & $past(mask)));
    // R3
    rd_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_rd_en && add_ok) |=>
            rd_q == (($past(rd_q) + PTR_W'($past(wdata))) & $past(mask)));
    // R4
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((add_wr_en || add_rd_en) && !add_ok) |=>
            ($stable(wr_q) && $stable(rd_q) && err_q));
    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !cfg_en) |=> err_q);
    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !cfg_en) |=> ovf_q);
    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_q & ~mask) == '0) && ((rd_q & ~mask) == '0)
        && lg_q >= LG_W'(LG_MIN) && lg_q <= LG_W'(LG_MAX));
endmodule

// File: rtl/qptr_ctrl.sv
// Module: qptr_ctrl (top)
// Register-bus front end for NUM_Q queue pointer blocks: decodes
// accesses, fans out add/config strobes and registers read data.
// Assumes bus_wr and bus_rd are single-cycle strobes.
module qptr_ctrl
    import qptr_pkg::*;
#(
    parameter int NUM_Q  = 8,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_Q-1:0]  q_not_empty
);
    logic [QIDX_W-1:0] qidx;
    reg_kind_e         kind;
    qstat_t            stat [NUM_Q];
    qstat_t            sel;
    logic [DATA_W-1:0] rd_next, rdata_q;

    qptr_decode #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .qidx (qidx),
        .kind (kind)
    );

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        logic hit;
        assign hit = (qidx == QIDX_W'(i));
        qptr_queue u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .add_rd_en (bus_wr && hit && kind == RK_ADD_RD),
            .add_wr_en (bus_wr && hit && kind == RK_ADD_WR),
            .cfg_en    (bus_wr && hit && kind == RK_CFG),
            .wdata     (bus_wdata),
            .stat      (stat[i]),
            .not_empty (q_not_empty[i])
        );
    end

    // Purpose: pick the addressed queue's state
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_Q; i++)
            if (qidx == QIDX_W'(i)) sel = stat[i];
    end

    // Purpose: format the addressed register for the read path
    always_comb begin
        rd_next = '0;
        case (kind)
            RK_STS_LO: rd_next = {(sel.rd == sel.wr), 13'd0, sel.rd};
            RK_STS_HI: rd_next = {sel.err, sel.ovf, 12'd0, sel.wr};
            RK_CFG:    rd_next = {27'd0, sel.lg};
            default:   rd_next = '0;
        endcase
    end

    // Purpose: register read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_next;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

    // R9
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);
    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == RK_NONE) |=> bus_rdata == '0);
endmodule

// File: tb/qptr_ctrl_tb.sv
module qptr_ctrl_tb;
    localparam int NQ = 4;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NQ-1:0] q_not_empty;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    int m_rd [NQ];
    int m_wr [NQ];
    int m_lg [NQ];
    bit m_ovf [NQ];
    bit m_err [NQ];

    always #4 clk = ~clk;

    qptr_ctrl #(.NUM_Q(NQ), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .q_not_empty(q_not_empty));

    function automatic logic [AW-1:0] qa(int q, int off);
        return AW'(32'h80000 + q * 32'h800 + off);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic int msk(int q);
        return (1 << m_lg[q]) - 1;
    endfunction

    task automatic m_add_wr(int q, int v);
        if (v > 63 || v < 0) m_err[q] = 1;
        else begin
            if (((m_wr[q] - m_rd[q]) & msk(q)) + v > msk(q)) m_ovf[q] = 1;
            m_wr[q] = (m_wr[q] + v) & msk(q);
        end
    endtask

    task automatic m_add_rd(int q, int v);
        if (v > 63 || v < 0) m_err[q] = 1;
        else m_rd[q] = (m_rd[q] + v) & msk(q);
    endtask

    task automatic m_cfg(int q, int lg);
        m_lg[q] = lg < 8 ? 8 : (lg > 18 ? 18 : lg);
        m_rd[q] = 0; m_wr[q] = 0; m_ovf[q] = 0; m_err[q] = 0;
    endtask

    // compare all readable state of queue q against the model
    task automatic cmp_q(int q, string req);
        logic [31:0] d, e;
        bus_read(qa(q, 'h8), d);
        e = {(m_rd[q] == m_wr[q]), 13'd0, 18'(m_rd[q])};
        chk(d == e, {req, " status-low R6"}, d, e);
        bus_read(qa(q, 'hC), d);
        e = {m_err[q], m_ovf[q], 12'd0, 18'(m_wr[q])};
        chk(d == e, {req, " status-high R6"}, d, e);
        e = {31'd0, (m_rd[q] != m_wr[q])};
        chk(q_not_empty[q] == e[0], {req, " not-empty R8"}, {31'd0, q_not_empty[q]}, e);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int q = 0; q < NQ; q++) begin
            m_rd[q] = 0; m_wr[q] = 0; m_lg[q] = 8; m_ovf[q] = 0; m_err[q] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state, R9 idle rdata
        chk(bus_rdata == 0, "R9 idle rdata", bus_rdata, 0);
        chk(q_not_empty == 0, "R11 not-empty after reset", 32'(q_not_empty), 0);
        for (int q = 0; q < NQ; q++) begin
            cmp_q(q, "R11");
            bus_read(qa(q, 'h10), d);
            chk(d == 8, "R11 reset size", d, 8);
            bus_read(qa(q, 'h0), d);
            chk(d == 0, "R1 add offset reads zero", d, 0);
            bus_read(qa(q, 'h4), d);
            chk(d == 0, "R1 add offset reads zero", d, 0);
        end
        @(negedge clk);
        chk(bus_rdata == 0, "R9 rdata zero after idle cycle", bus_rdata, 0);

        // R2 R3 R5 sweep of every legal add on every queue
        for (int q = 0; q < NQ; q++) begin
            for (int v = 0; v < 64; v++) begin
                bus_write(qa(q, 'h4), 32'(v)); m_add_wr(q, v);
                cmp_q(q, "R2 R5 write-add sweep");
            end
            for (int v = 63; v >= 0; v--) begin
                bus_write(qa(q, 'h0), 32'(v)); m_add_rd(q, v);
                cmp_q(q, "R3 read-add sweep");
            end
            // other queues untouched (R1 window selection)
            for (int o = 0; o < NQ; o++)
                if (o != q) cmp_q(o, "R1 isolation");
        end

        // R7 config clears, R5 exact boundary at size 256
        bus_write(qa(1, 'h10), 8); m_cfg(1, 8);
        cmp_q(1, "R7 config clear");
        for (int k = 0; k < 4; k++) begin
            bus_write(qa(1, 'h4), 63); m_add_wr(1, 63);
        end
        bus_write(qa(1, 'h4), 3); m_add_wr(1, 3);
        bus_read(qa(1, 'hC), d);
        chk(d == 32'd255, "R5 occupancy 255 no overflow", d, 255);
        bus_write(qa(1, 'h4), 1); m_add_wr(1, 1);
        bus_read(qa(1, 'hC), d);
        chk(d == 32'h4000_0000, "R5 overflow at 256 wrap", d, 32'h4000_0000);
        chk(q_not_empty[1] == 1'b0, "R8 wrapped equal pointers", 32'(q_not_empty[1]), 0);

        // R4 rejected adds
        bus_write(qa(2, 'h10), 8); m_cfg(2, 8);
        bus_write(qa(2, 'h4), 10); m_add_wr(2, 10);
        bus_write(qa(2, 'h4), 64); m_add_wr(2, 64);
        cmp_q(2, "R4 reject 64 on write ptr");
        bus_write(qa(3, 'h10), 9); m_cfg(3, 9);
        bus_write(qa(3, 'h0), 32'h8000_0001); m_add_rd(3, -1);
        cmp_q(3, "R4 reject high bit on read ptr");
        bus_write(qa(3, 'h4), 5); m_add_wr(3, 5);
        cmp_q(3, "R4 error sticky after good add");
        bus_read(qa(3, 'h10), d);
        chk(d == 9, "R7 size readback", d, 9);

        // R7 clamps and largest size
        bus_write(qa(0, 'h10), 3); m_cfg(0, 3);
        bus_read(qa(0, 'h10), d);
        chk(d == 8, "R7 clamp low", d, 8);
        bus_write(qa(0, 'h10), 31); m_cfg(0, 31);
        bus_read(qa(0, 'h10), d);
        chk(d == 18, "R7 clamp high", d, 18);
        for (int k = 0; k < 10; k++) begin
            bus_write(qa(0, 'h4), 63); m_add_wr(0, 63);
        end
        cmp_q(0, "R2 large size no wrap");

        // R10 unmapped accesses
        bus_write(qa(NQ, 'h4), 7);
        bus_write(qa(0, 'h14), 7);
        bus_write(AW'(32'h00004), 7);
        bus_write(AW'(32'h00010), 8);
        bus_write(qa(0, 'h5), 7);
        for (int q = 0; q < NQ; q++) cmp_q(q, "R10 writes ignored");
        bus_read(qa(NQ, 'h8), d);
        chk(d == 0, "R10 index beyond NUM_Q", d, 0);
        bus_read(qa(0, 'h18), d);
        chk(d == 0, "R10 unlisted offset", d, 0);
        bus_read(AW'(32'h0000C), d);
        chk(d == 0, "R10 outside region", d, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule